// File: doc/BRIEF.md
# Sync-Character Byte Framer (Receive)

This block receives a serial stream that carries no start or stop bits. A separate receive clock supplies the bit timing, and that clock reaches this block as a one-cycle enable, `bit_en`, in the system clock domain. Every enabled cycle shifts one bit into a sliding window.

While it is hunting, the block compares the window against a programmable sync character after every bit. The first match fixes the byte boundary. From then on the block cuts the stream into bytes at that boundary. A byte equal to the sync character is treated as idle fill: it is dropped and reported with a single-cycle `sync_det` pulse. Every other byte goes to a valid/ready output.

The serial input cannot be stalled, so back-pressure has no effect upstream. While `out_valid` is high and `out_ready` is low, the held byte stays on `out_data`. If another byte completes before the handshake, it replaces the held one and the earlier byte is lost. A pulse on `hunt_req` drops alignment and restarts the hunt. The window contents are kept, so the next match can come on the very next bit.

Top module: `sync_framer_rx`

## Requirements
- R1: While reset is low, `out_valid`, `in_sync` and `sync_det` are all low.
- R2: In hunt, the window is tested on every enabled bit, the newest bit included. The first match sets `in_sync` and pulses `sync_det` for one cycle, one clock after the enabled bit.
- R3: After acquisition, each group of 8 enabled bits counted from the matching bit forms one byte. The first bit of the group received lands in bit 7 (MSB first). A byte that does not equal the sync character is presented on `out_data` with `out_valid` high, one clock after its last bit.
- R4: In sync, an aligned byte equal to `sync_pat` is never output and pulses `sync_det` for one cycle.
- R5: In sync, a copy of the sync pattern that straddles a byte boundary neither changes the alignment nor pulses `sync_det`.
- R6: A `hunt_req` pulse clears `in_sync` on the next clock. No byte is output until a new match is found.
- R7: `bit_in` is ignored in every cycle where `bit_en` is low.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. A byte that completes in that time overwrites the held byte.
- R9: After a handshake (`out_valid` and `out_ready` both high) with no new byte completing, `out_valid` is low on the next clock.
- R10: After reset, no match is accepted until 8 enabled bits have been received.
- R11: `sync_pat` is an input and can be changed. A byte that matched an earlier pattern is output as ordinary data once the pattern has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe per received bit (receive-clock enable) |
| bit_in | input | 1 | Serial data bit, sampled when `bit_en` is high |
| sync_pat | input | 8 | Sync character to hunt for (normally 0x16) |
| hunt_req | input | 1 | Pulse to drop alignment and hunt again |
| out_data | output | 8 | Received data byte |
| out_valid | output | 1 | `out_data` holds an undelivered byte |
| out_ready | input | 1 | Downstream accepts the byte |
| in_sync | output | 1 | Byte alignment acquired |
| sync_det | output | 1 | One-cycle pulse on each detected sync character |

## Verification
The first stimulus is a sync character preceded by a few junk bits. It shows that the block searches bit by bit rather than at a fixed phase. Runs of back-to-back fill mixed with data show that fill is dropped while data passes through. A data pair whose bits contain the pattern across the byte boundary shows that, once in sync, only aligned bytes are compared.

Further tests cover:
- a hunt request followed by a non-matching byte, and then a new sync;
- a change of pattern, after which the old sync value arrives as data;
- toggling of the data pin with the enable low, part-way through a byte;
- a stalled consumer that receives two bytes, to expose the hold and overwrite rules;
- an all-zero pattern straight after reset, to show that a partly filled window cannot match.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_SYNC = 1'b1
  } sfr_state_t;

  localparam int unsigned SFR_DEF_WIDTH = 8;
endpackage

// File: rtl/sfr_window.sv
module sfr_window #(
  parameter int unsigned W         = 8,
  parameter bit          MSB_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         bit_in,
  output logic [W-1:0] win_next,
  output logic         win_full_next
);
  localparam int unsigned FW = $clog2(W + 1);
  localparam logic [FW-1:0] FILL_LAST = FW'(W - 1);
  localparam logic [FW-1:0] FILL_MAX  = FW'(W);

  logic [W-1:0]  win_q;
  logic [FW-1:0] fill_q;

  generate
    if (MSB_FIRST) begin : g_msb
      assign win_next = {win_q[W-2:0], bit_in};
    end else begin : g_lsb
      assign win_next = {bit_in, win_q[W-1:1]};
    end
  endgenerate

  assign win_full_next = (fill_q >= FILL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      win_q <= win_next;
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfr_align.sv
module sfr_align
  import sfr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         hunt_req,
  input  logic [W-1:0] win_next,
  input  logic         win_full_next,
  input  logic [W-1:0] sync_pat,
  output logic         byte_stb,
  output logic         in_sync,
  output logic         sync_det
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  sfr_state_t  state_q;
  logic [CW-1:0] cnt_q;
  logic        match;
  logic        step;
  logic        boundary;
  logic        acquire;
  logic        fill_hit;

  assign match    = (win_next == sync_pat);
  assign step     = bit_en && !hunt_req;
  assign boundary = (state_q == ST_SYNC) && (cnt_q == CNT_LAST);
  assign acquire  = step && (state_q == ST_HUNT) && win_full_next && match;
  assign fill_hit = step && boundary && match;
  assign byte_stb = step && boundary && !match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      cnt_q    <= '0;
      sync_det <= 1'b0;
    end else begin
      sync_det <= acquire || fill_hit;
      if (hunt_req) begin
        state_q <= ST_HUNT;
        cnt_q   <= '0;
      end else if (acquire) begin
        state_q <= ST_SYNC;
        cnt_q   <= '0;
      end else if (step && state_q == ST_SYNC) begin
        cnt_q <= boundary ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign in_sync = (state_q == ST_SYNC);
endmodule

// File: rtl/sfr_outreg.sv
module sfr_outreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      out_data  <= load_data;
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_framer_rx.sv
module sync_framer_rx #(
  parameter int unsigned W         = sfr_pkg::SFR_DEF_WIDTH,
  parameter bit          MSB_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         bit_in,
  input  logic [W-1:0] sync_pat,
  input  logic         hunt_req,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         in_sync,
  output logic         sync_det
);
  logic [W-1:0] win_next;
  logic         win_full_next;
  logic         byte_stb;

  sfr_window #(.W(W), .MSB_FIRST(MSB_FIRST)) u_window (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .bit_in        (bit_in),
    .win_next      (win_next),
    .win_full_next (win_full_next)
  );

  sfr_align #(.W(W)) u_align (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .hunt_req      (hunt_req),
    .win_next      (win_next),
    .win_full_next (win_full_next),
    .sync_pat      (sync_pat),
    .byte_stb      (byte_stb),
    .in_sync       (in_sync),
    .sync_det      (sync_det)
  );

  sfr_outreg #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (byte_stb),
    .load_data (win_next),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid)
  );
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_en,
  input logic         hunt_req,
  input logic [W-1:0] out_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic         in_sync,
  input logic         sync_det
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!out_valid && !in_sync && !sync_det);
    end
  end

  assert_acquire_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> sync_det);

  assert_data_only_in_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_sync));

  assert_hunt_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_req |=> !in_sync);

  assert_idle_no_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !sync_det && !$rose(out_valid));

  assert_idle_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !hunt_req) |=> $stable(in_sync));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !bit_en) |=> out_valid && $stable(out_data));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !bit_en) |=> !out_valid);
endmodule

bind sync_framer_rx sfr_checker #(.W(W)) u_sfr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .hunt_req  (hunt_req),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_sync   (in_sync),
  .sync_det  (sync_det)
);

// File: tb/tb_sync_framer_rx.sv
`timescale 1ns/1ps
module tb_sync_framer_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] sync_pat = 8'h16;
  logic       hunt_req = 1'b0;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       in_sync;
  logic       sync_det;

  int checks = 0;
  int failures = 0;
  int nsync = 0;
  logic [7:0] cap[$];
  bit done = 1'b0;

  always #5 clk = ~clk;

  sync_framer_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .sync_pat(sync_pat), .hunt_req(hunt_req), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .in_sync(in_sync),
    .sync_det(sync_det)
  );

  // Sample 1 ns before each rising edge.
  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      if (out_valid && out_ready) cap.push_back(out_data);
      if (sync_det) nsync++;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_caps(string tag, logic [7:0] e[$]);
    check({tag, " count"}, cap.size(), e.size());
    for (int i = 0; i < e.size() && i < cap.size(); i++)
      check({tag, " byte"}, cap[i], e[i]);
  endtask

  task automatic clear_obs();
    @(negedge clk);
    cap.delete();
    nsync = 0;
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
    bit_in = ~b;
    @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_hunt();
    @(negedge clk);
    hunt_req = 1'b1;
    @(negedge clk);
    hunt_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", out_valid, 0);
    check("R1 in_sync in reset", in_sync, 0);
    check("R1 sync_det in reset", sync_det, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_acquire();
    clear_obs();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_byte(8'h16);
    check("R2 in_sync after sliding match", in_sync, 1);
    check("R2 sync_det on acquire", nsync, 1);
    check("R2 no byte on acquire", cap.size(), 0);
    send_byte(8'hA5);
    send_byte(8'h3C);
    check_caps("R3 bytes after acquire", '{8'hA5, 8'h3C});
  endtask

  task automatic t_fill();
    clear_obs();
    send_byte(8'h16); send_byte(8'h16);
    send_byte(8'h55); send_byte(8'h16);
    check_caps("R4 fill dropped", '{8'h55});
    check("R4 fill pulses", nsync, 3);
  endtask

  task automatic t_straddle();
    clear_obs();
    send_byte(8'h01); send_byte(8'h60);
    check_caps("R5 straddle keeps alignment", '{8'h01, 8'h60});
    check("R5 no straddle pulse", nsync, 0);
    check("R5 still in sync", in_sync, 1);
  endtask

  task automatic t_hunt();
    clear_obs();
    pulse_hunt();
    check("R6 in_sync drops", in_sync, 0);
    send_byte(8'hA5);
    check("R6 no byte while hunting", cap.size(), 0);
    check("R6 no pulse while hunting", nsync, 0);
    send_byte(8'h16);
    check("R6 reacquire", in_sync, 1);
    send_byte(8'h3C);
    check_caps("R6 byte after reacquire", '{8'h3C});
  endtask

  task automatic t_new_pattern();
    clear_obs();
    sync_pat = 8'h7E;
    pulse_hunt();
    send_byte(8'h7E);
    check("R11 acquire on new pattern", in_sync, 1);
    send_byte(8'h16);
    send_byte(8'h7E);
    check_caps("R11 old sync value is data", '{8'h16});
    check("R11 pulses for new pattern", nsync, 2);
  endtask

  task automatic t_enable_gate();
    clear_obs();
    for (int i = 7; i >= 4; i--) send_bit(8'h5A >> i);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      bit_in = i[0];
    end
    for (int i = 3; i >= 0; i--) send_bit(8'h5A >> i);
    check_caps("R7 disabled bits ignored", '{8'h5A});
    check("R7 in_sync kept", in_sync, 1);
  endtask

  task automatic t_backpressure();
    clear_obs();
    out_ready = 1'b0;
    send_byte(8'h11);
    check("R8 valid raised", out_valid, 1);
    check("R8 data held", out_data, 8'h11);
    repeat (10) @(negedge clk);
    check("R8 still valid", out_valid, 1);
    check("R8 data stable", out_data, 8'h11);
    send_byte(8'h22);
    check("R8 overwrite", out_data, 8'h22);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 valid clears after handshake", out_valid, 0);
    check_caps("R9 single delivery", '{8'h22});
  endtask

  task automatic t_fill_guard();
    do_reset();
    clear_obs();
    sync_pat = 8'h00;
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    check("R10 no match on partial window", in_sync, 0);
    check("R10 no pulse on partial window", nsync, 0);
    send_bit(1'b0);
    check("R10 match at eighth bit", in_sync, 1);
    check("R10 one pulse", nsync, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_acquire();
    t_fill();
    t_straddle();
    t_hunt();
    t_new_pattern();
    t_enable_gate();
    t_backpressure();
    t_fill_guard();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule